// File: doc/BRIEF.md
# Fault Response Controller

This block decides what one power channel does when its fault detector fires. A single programmable response byte holds three fields. The action field picks one of four choices: ride through the fault, ride through it for a number of time ticks and then shut down, shut down at once, or an unsupported code. The retry field picks between latching off and retrying without limit. The delay field sets the tick count for the deferred shutdown. Every detected fault is recorded in a sticky status bit and raises alert, whatever the action field holds.

When the channel shuts down, `disable_o` goes high. In latch-off mode it stays high until one of three recovery events occurs: a rising edge on the run input, a rising edge on the on/off command, or reset. In retry mode the block first waits out the retry delay, counted in ticks from the moment of shutdown. It then pulses `restart_o` for one cycle and releases `disable_o` in that same cycle. If the fault is still present, the channel goes through the response again.

A write whose action field or retry field is not supported is refused. The stored response stays as it was, and a sticky command-fault flag is set.

Top module: `fault_resp_ctrl`

## Requirements
- R1: After reset, `disable_o`, `restart_o`, `status_o`, `alert_o` and `cmd_fault_o` are all 0. The stored response is 8'h80, so a fault shuts the channel down at once and latches off.
- R2: A write (`resp_wr_i` high for one cycle) is accepted only when both fields hold a supported code. Bits [7:6] must be 00 (ride through), 01 (deferred shutdown) or 10 (immediate shutdown). Bits [5:3] must be 000 (latch off) or 111 (retry). Bits [2:0] are the deferred-shutdown tick count. An accepted write takes effect from the next cycle.
- R3: A write with bits [7:6] = 11, or with bits [5:3] other than 000 or 111, leaves the stored response unchanged. It sets `cmd_fault_o` one cycle later, and the flag then stays set until reset. Recovery events do not clear it.
- R4: A cycle in which `fault_i` is sampled high sets `status_o` one cycle later, under every action code. `status_o` stays set until a recovery event that occurs while the fault is absent. `alert_o` is high exactly when `status_o` or `cmd_fault_o` is high.
- R5: With action 00, `disable_o` never rises, however long the fault lasts.
- R6: With action 10, `disable_o` is high in the cycle after the first cycle in which `fault_i` is sampled high.
- R7: With action 01 and tick count D, the fault must persist while D ticks are counted. `disable_o` then rises one cycle after the D-th tick. If the fault drops earlier, the count restarts from zero.
- R8: In latch-off mode, a shut-down channel stays disabled after the fault goes away. It is released in the cycle after a rising edge of `run_i` or of `cmd_on_i`, or by reset.
- R9: In retry mode, the block counts ticks from shutdown. Once the count reaches `retry_dly_i`, `restart_o` is high for exactly one cycle, and `disable_o` falls in that same cycle. A disable is released only by such a restart or by a recovery event.
- R10: A recovery event during the retry wait releases `disable_o` without any `restart_o` pulse. No pulse follows later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fault_i | input | 1 | Fault condition level from the channel detector |
| resp_byte_i | input | 8 | Response byte to store: action [7:6], retry [5:3], delay [2:0] |
| resp_wr_i | input | 1 | One-cycle write strobe for `resp_byte_i` |
| retry_dly_i | input | RETRY_W | Retry wait in ticks |
| tick_i | input | 1 | Time-base tick, one cycle wide |
| run_i | input | 1 | Run level; a rising edge is a recovery event |
| cmd_on_i | input | 1 | On/off command level; a rising edge is a recovery event |
| disable_o | output | 1 | Channel shut down by this block |
| restart_o | output | 1 | One-cycle restart request after a retry wait |
| status_o | output | 1 | Sticky fault status bit |
| alert_o | output | 1 | Alert: status or command fault pending |
| cmd_fault_o | output | 1 | Sticky flag: an unsupported response byte was written |

## Verification
The assertions take for granted that `fault_i`, `tick_i`, `run_i` and `cmd_on_i` are synchronous to `clk`. They also assume that a release of `disable_o` can only follow a restart or a rising edge of run or the on/off command seen in the cycle before. The stimulus changes every input only on the falling clock edge and pulses ticks one cycle at a time. It holds `retry_dly_i` large while a fault is active, so a retry cannot fire in the middle of a measured window. The sweep writes all 256 response bytes, each from a fresh reset. It derives the expected action, retry mode and refusal from the byte's bits.

// File: rtl/frc_pkg.sv
package frc_pkg;

  localparam int RESP_W = 8;
  localparam int DLY_W  = 3;
  localparam logic [RESP_W-1:0] RESP_RESET = 8'h80;

  typedef enum logic [1:0] {
    ACT_RIDE  = 2'b00,
    ACT_DEFER = 2'b01,
    ACT_STOP  = 2'b10,
    ACT_BAD   = 2'b11
  } act_e;

  typedef struct packed {
    act_e             act;
    logic             retry;
    logic [DLY_W-1:0] dly;
  } resp_cfg_t;

  typedef enum logic [1:0] {
    SEQ_RUN,
    SEQ_HOLD,
    SEQ_LATCHED,
    SEQ_BACKOFF
  } seq_e;

  function automatic logic resp_ok(input logic [RESP_W-1:0] b);
    return (b[7:6] != 2'b11) && ((b[5:3] == 3'b000) || (b[5:3] == 3'b111));
  endfunction

  function automatic resp_cfg_t resp_unpack(input logic [RESP_W-1:0] b);
    resp_cfg_t c;
    c.act   = act_e'(b[7:6]);
    c.retry = b[5];
    c.dly   = b[2:0];
    return c;
  endfunction

endpackage

// File: rtl/frc_cfg_reg.sv
module frc_cfg_reg
  import frc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_i,
  input  logic [RESP_W-1:0] byte_i,
  output resp_cfg_t         cfg_o,
  output logic              reject_o
);

  resp_cfg_t cfg_q;
  logic      accept;

  assign accept   = wr_i && resp_ok(byte_i);
  assign reject_o = wr_i && !resp_ok(byte_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= resp_unpack(RESP_RESET);
    end else if (accept) begin
      cfg_q <= resp_unpack(byte_i);
    end
  end

  assign cfg_o = cfg_q;

endmodule

// File: rtl/frc_recover.sv
module frc_recover (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic on_i,
  output logic clear_o
);

  logic run_q;
  logic on_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      on_q  <= 1'b0;
    end else begin
      run_q <= run_i;
      on_q  <= on_i;
    end
  end

  assign clear_o = (run_i && !run_q) || (on_i && !on_q);

endmodule

// File: rtl/frc_seq.sv
module frc_seq
  import frc_pkg::*;
#(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault_i,
  input  logic               tick_i,
  input  logic               clear_i,
  input  resp_cfg_t          cfg_i,
  input  logic [RETRY_W-1:0] retry_dly_i,
  output logic               disable_o,
  output logic               restart_o
);

  localparam int CNT_W = (RETRY_W > DLY_W) ? RETRY_W : DLY_W + 1;

  seq_e             st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             dis_q, dis_d;
  logic             rs_q, rs_d;
  logic             hold_done;
  logic             wait_done;

  assign hold_done = cnt_q >= CNT_W'(cfg_i.dly);
  assign wait_done = cnt_q >= CNT_W'(retry_dly_i);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    dis_d = dis_q;
    rs_d  = 1'b0;
    if (clear_i) begin
      st_d  = SEQ_RUN;
      cnt_d = '0;
      dis_d = 1'b0;
    end else begin
      unique case (st_q)
        SEQ_RUN: begin
          cnt_d = '0;
          if (fault_i) begin
            if (cfg_i.act == ACT_DEFER) begin
              st_d = SEQ_HOLD;
            end else if (cfg_i.act == ACT_STOP) begin
              dis_d = 1'b1;
              st_d  = cfg_i.retry ? SEQ_BACKOFF : SEQ_LATCHED;
            end
          end
        end
        SEQ_HOLD: begin
          if (!fault_i) begin
            st_d  = SEQ_RUN;
            cnt_d = '0;
          end else if (hold_done) begin
            dis_d = 1'b1;
            cnt_d = '0;
            st_d  = cfg_i.retry ? SEQ_BACKOFF : SEQ_LATCHED;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        SEQ_LATCHED: begin
          cnt_d = '0;
        end
        SEQ_BACKOFF: begin
          if (wait_done) begin
            st_d  = SEQ_RUN;
            cnt_d = '0;
            dis_d = 1'b0;
            rs_d  = 1'b1;
          end else if (tick_i) begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          st_d  = SEQ_RUN;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= SEQ_RUN;
      cnt_q <= '0;
      dis_q <= 1'b0;
      rs_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      dis_q <= dis_d;
      rs_q  <= rs_d;
    end
  end

  assign disable_o = dis_q;
  assign restart_o = rs_q;

endmodule

// File: rtl/frc_flags.sv
module frc_flags (
  input  logic clk,
  input  logic rst,
  input  logic fault_i,
  input  logic clear_i,
  input  logic reject_i,
  output logic status_o,
  output logic cmdf_o,
  output logic alert_o
);

  logic status_q, status_d;
  logic cmdf_q, cmdf_d;
  logic alert_q;

  assign status_d = (status_q && !clear_i) || fault_i;
  assign cmdf_d   = cmdf_q || reject_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      cmdf_q   <= 1'b0;
      alert_q  <= 1'b0;
    end else begin
      status_q <= status_d;
      cmdf_q   <= cmdf_d;
      alert_q  <= status_d || cmdf_d;
    end
  end

  assign status_o = status_q;
  assign cmdf_o   = cmdf_q;
  assign alert_o  = alert_q;

endmodule

// File: rtl/fault_resp_ctrl.sv
module fault_resp_ctrl
  import frc_pkg::*;
#(
  parameter int RETRY_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fault_i,
  input  logic [7:0]         resp_byte_i,
  input  logic               resp_wr_i,
  input  logic [RETRY_W-1:0] retry_dly_i,
  input  logic               tick_i,
  input  logic               run_i,
  input  logic               cmd_on_i,
  output logic               disable_o,
  output logic               restart_o,
  output logic               status_o,
  output logic               alert_o,
  output logic               cmd_fault_o
);

  resp_cfg_t cfg;
  logic      reject;
  logic      clear;

  frc_cfg_reg u_cfg (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (resp_wr_i),
    .byte_i   (resp_byte_i),
    .cfg_o    (cfg),
    .reject_o (reject)
  );

  frc_recover u_rec (
    .clk     (clk),
    .rst     (rst),
    .run_i   (run_i),
    .on_i    (cmd_on_i),
    .clear_o (clear)
  );

  frc_seq #(.RETRY_W(RETRY_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .fault_i     (fault_i),
    .tick_i      (tick_i),
    .clear_i     (clear),
    .cfg_i       (cfg),
    .retry_dly_i (retry_dly_i),
    .disable_o   (disable_o),
    .restart_o   (restart_o)
  );

  frc_flags u_flags (
    .clk      (clk),
    .rst      (rst),
    .fault_i  (fault_i),
    .clear_i  (clear),
    .reject_i (reject),
    .status_o (status_o),
    .cmdf_o   (cmd_fault_o),
    .alert_o  (alert_o)
  );

endmodule

// File: rtl/frc_checker.sv
module frc_checker (
  input logic       clk,
  input logic       rst,
  input logic       fault_i,
  input logic [1:0] act_bits,
  input logic       resp_wr_i,
  input logic       run_i,
  input logic       cmd_on_i,
  input logic       disable_o,
  input logic       restart_o,
  input logic       status_o,
  input logic       alert_o,
  input logic       cmd_fault_o
);

  logic run_seen;
  logic on_seen;
  logic recover_ev;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_seen <= 1'b0;
      on_seen  <= 1'b0;
    end else begin
      run_seen <= run_i;
      on_seen  <= cmd_on_i;
    end
  end

  assign recover_ev = (run_i && !run_seen) || (cmd_on_i && !on_seen);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!disable_o && !restart_o && !status_o && !cmd_fault_o)); // R1

  AST_BAD_ACTION_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    (resp_wr_i && act_bits == 2'b11) |=> cmd_fault_o); // R3

  AST_CMD_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    cmd_fault_o |=> cmd_fault_o); // R3

  AST_STATUS_ON_FAULT: assert property (@(posedge clk) disable iff (rst)
    fault_i |=> status_o); // R4

  AST_ALERT_COVERS: assert property (@(posedge clk) disable iff (rst)
    (status_o || cmd_fault_o) |-> alert_o); // R4

  AST_RELEASE_CAUSED: assert property (@(posedge clk) disable iff (rst)
    $fell(disable_o) |-> (restart_o || $past(recover_ev))); // R8

  AST_RESTART_SINGLE: assert property (@(posedge clk) disable iff (rst)
    restart_o |=> !restart_o); // R9

  AST_RESTART_RELEASES: assert property (@(posedge clk) disable iff (rst)
    restart_o |-> (!disable_o && $past(disable_o))); // R9

endmodule

bind fault_resp_ctrl frc_checker u_frc_checker (
  .clk         (clk),
  .rst         (rst),
  .fault_i     (fault_i),
  .act_bits    (resp_byte_i[7:6]),
  .resp_wr_i   (resp_wr_i),
  .run_i       (run_i),
  .cmd_on_i    (cmd_on_i),
  .disable_o   (disable_o),
  .restart_o   (restart_o),
  .status_o    (status_o),
  .alert_o     (alert_o),
  .cmd_fault_o (cmd_fault_o)
);

// File: tb/tb_fault_resp_ctrl.sv
`timescale 1ns/1ps
module tb_fault_resp_ctrl;

  localparam int RETRY_W = 8;

  logic               clk = 1'b0;
  logic               rst;
  logic               fault;
  logic [7:0]         resp_byte;
  logic               resp_wr;
  logic [RETRY_W-1:0] retry_dly;
  logic               tick;
  logic               run;
  logic               cmd_on;
  logic               dis, rs, status, alert, cmdf;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  fault_resp_ctrl #(.RETRY_W(RETRY_W)) dut (
    .clk         (clk),
    .rst         (rst),
    .fault_i     (fault),
    .resp_byte_i (resp_byte),
    .resp_wr_i   (resp_wr),
    .retry_dly_i (retry_dly),
    .tick_i      (tick),
    .run_i       (run),
    .cmd_on_i    (cmd_on),
    .disable_o   (dis),
    .restart_o   (rs),
    .status_o    (status),
    .alert_o     (alert),
    .cmd_fault_o (cmdf)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: %s got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; fault = 1'b0; tick = 1'b0; resp_wr = 1'b0; resp_byte = 8'h00;
    run = 1'b1; cmd_on = 1'b1; retry_dly = '0;
    cyc(2);
    rst = 1'b0;
    cyc(1);
  endtask

  task automatic write_resp(input logic [7:0] b);
    resp_byte = b; resp_wr = 1'b1;
    cyc(1);
    resp_wr = 1'b0;
  endtask

  task automatic pulse_tick(input int n);
    for (int k = 0; k < n; k++) begin
      tick = 1'b1;
      cyc(1);
      tick = 1'b0;
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    // R1: reset state and default response
    chk("R1", "disable", dis, 1'b0);
    chk("R1", "restart", rs, 1'b0);
    chk("R1", "status", status, 1'b0);
    chk("R1", "alert", alert, 1'b0);
    chk("R1", "cmd_fault", cmdf, 1'b0);
    fault = 1'b1; cyc(1);
    chk("R1", "default immediate disable", dis, 1'b1);
    fault = 1'b0; cyc(3);
    chk("R1", "default latches", dis, 1'b1);

    // Sweep of every response byte
    for (int b = 0; b < 256; b++) begin
      logic [7:0] bv;
      logic ok, rty;
      logic [1:0] act;
      int d;
      bv  = b[7:0];
      ok  = (bv[7:6] != 2'b11) && (bv[5:3] == 3'b000 || bv[5:3] == 3'b111);
      act = ok ? bv[7:6] : 2'b10;
      rty = ok ? (bv[5:3] == 3'b111) : 1'b0;
      d   = ok ? int'(bv[2:0]) : 0;
      do_reset();
      retry_dly = 8'd200;
      write_resp(bv);
      chk(ok ? "R2" : "R3", "cmd_fault after write", cmdf, !ok);
      chk("R4", "alert before fault", alert, !ok);
      fault = 1'b1; cyc(1);
      chk("R4", "status on fault", status, 1'b1);
      chk("R6", "disable one cycle after fault", dis, act == 2'b10);
      pulse_tick(d); cyc(2);
      chk(act == 2'b00 ? "R5" : "R7", "disable after delay", dis, act != 2'b00);
      fault = 1'b0; retry_dly = '0; cyc(3);
      chk(rty ? "R9" : "R8", "disable after fault gone", dis, act != 2'b00 && !rty);
      chk("R4", "status sticky", status, 1'b1);
      if (bv[0]) begin
        run = 1'b0; cyc(1); run = 1'b1; cyc(1);
      end else begin
        cmd_on = 1'b0; cyc(1); cmd_on = 1'b1; cyc(1);
      end
      chk("R8", "released by recovery event", dis, 1'b0);
      chk("R4", "status cleared by recovery", status, 1'b0);
      chk("R3", "cmd_fault survives recovery", cmdf, !ok);
    end

    // R7: exact deferral and counter restart (01_000_011)
    do_reset();
    write_resp(8'h43);
    fault = 1'b1; cyc(1);
    pulse_tick(2);
    chk("R7", "not yet after 2 of 3 ticks", dis, 1'b0);
    fault = 1'b0; cyc(2);
    fault = 1'b1; cyc(1);
    pulse_tick(2);
    chk("R7", "count restarted after fault drop", dis, 1'b0);
    pulse_tick(1);
    chk("R7", "third tick just counted", dis, 1'b0);
    cyc(1);
    chk("R7", "shutdown after third tick", dis, 1'b1);

    // R9: retry wait and single restart pulse (10_111_000)
    do_reset();
    write_resp(8'hB8);
    retry_dly = 8'd3;
    fault = 1'b1; cyc(1);
    chk("R9", "shutdown", dis, 1'b1);
    fault = 1'b0;
    pulse_tick(2);
    chk("R9", "still waiting", dis, 1'b1);
    chk("R9", "no early restart", rs, 1'b0);
    pulse_tick(1);
    chk("R9", "last tick counted", rs, 1'b0);
    cyc(1);
    chk("R9", "restart pulse", rs, 1'b1);
    chk("R9", "released with restart", dis, 1'b0);
    cyc(1);
    chk("R9", "restart one cycle", rs, 1'b0);

    // R10: recovery during retry wait, no pulse
    retry_dly = 8'd50;
    fault = 1'b1; cyc(1);
    fault = 1'b0;
    chk("R10", "shutdown before recovery", dis, 1'b1);
    cmd_on = 1'b0; cyc(1); cmd_on = 1'b1; cyc(1);
    chk("R10", "released by on command", dis, 1'b0);
    chk("R10", "no restart on recovery", rs, 1'b0);
    for (int k = 0; k < 60; k++) begin
      tick = 1'b1; cyc(1); tick = 1'b0;
      if (rs) chk("R10", "late restart", rs, 1'b0);
    end
    chk("R10", "no restart later", rs, 1'b0);

    // R3: refused write keeps previous response (continue stays)
    do_reset();
    write_resp(8'h00);
    write_resp(8'hC0);
    chk("R3", "cmd_fault set", cmdf, 1'b1);
    fault = 1'b1; cyc(4);
    chk("R3", "previous ride-through kept", dis, 1'b0);
    fault = 1'b0;

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run hung got %0d expected %0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule